// File: doc/BRIEF.md
# Dead-Time Current Polarity Sampler

This block supplies one current-polarity bit per phase of a three-phase complementary PWM stage. A dead-time distortion correction stage downstream uses the bits to pick the sign of its correction. A two-bit mode input picks where each bit comes from.

In the two software modes, the bits come from a software-written polarity word. In the dead-time mode, each phase's current-sense pin is captured while both gates of that phase are off. In the period-point mode, the pins are captured once per PWM period, at a fixed counter position.

The sense pins are asynchronous, so each one passes through a two-flop synchronizer first. The mode input has no shadow register: a new code acts on the next clock edge, even in the middle of a period. The gate drivers, the PWM counter and the correction arithmetic are outside this block.

Top module: `dtc_polarity_top`

## Requirements
- R1: While `rst` is high, every `pol_out` bit is 0 and every captured polarity is cleared to 0.
- R2: With `corr_mode` equal to 2'b00 or 2'b01, `pol_out` equals the `sw_pol` value seen at the previous rising clock edge.
- R3: With `corr_mode` equal to 2'b10, a phase's dead-time window is a run of cycles in which its `gate_hi` and `gate_lo` bits are both 0. The first edge after the window holds the closing edge, where a gate bit returns to 1. At the closing edge, the captured polarity takes the synchronized sense level of the last cycle of that window.
- R4: In mode 2'b10, if the phase's `duty_limit` bit is 1 at the closing edge, the captured polarity keeps its previous value.
- R5: In mode 2'b11 with `center_mode`=1, the captured polarity of every phase takes the synchronized sense level at each edge where `cnt_pos` equals `cnt_period`>>1.
- R6: In mode 2'b11 with `center_mode`=0, the capture happens at each edge where `cnt_pos` equals `cnt_period`-1.
- R7: In mode 2'b11, the capture happens whatever the value of `duty_limit`.
- R8: With `corr_mode[1]`=1, `pol_out` shows the captured polarity as it stood before the previous edge. A change of `corr_mode` shows on `pol_out` after a single edge.
- R9: A level on `sense_in` reaches the capture logic two rising edges after it is applied.
- R10: In mode 2'b11, closing a dead-time window does not change the captured polarity. In the software modes, nothing changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_in | input | NPH | Asynchronous current-sense pins, one per phase |
| gate_hi | input | NPH | Top gate state per phase, 1 = on |
| gate_lo | input | NPH | Bottom gate state per phase, 1 = on |
| cnt_pos | input | CW | PWM counter position, 0 to cnt_period-1 |
| cnt_period | input | CW | PWM period in counts |
| center_mode | input | 1 | 1 = center-aligned, 0 = edge-aligned |
| duty_limit | input | NPH | Per phase: duty is at 0% or 100% |
| sw_pol | input | NPH | Software polarity bits |
| corr_mode | input | 2 | Polarity source: 00/01 software, 10 dead-time, 11 period point |
| pol_out | output | NPH | Registered polarity bits |

## Verification
In the software modes, `pol_out` is due one edge after `sw_pol`. In the sampled modes, a sense level first needs two edges to reach the capture logic. It is captured at a window close or a period point, and it reaches `pol_out` one edge after the capture. A reference model in the bench advances at each rising edge and is fed the same inputs. Inputs change only at falling edges, and `pol_out` is compared with the model at each falling edge, so every one of these latencies is checked on every cycle.

// File: rtl/dtc_pol_pkg.sv
package dtc_pol_pkg;
  typedef enum logic [1:0] {
    SRC_SW_A  = 2'b00,
    SRC_SW_B  = 2'b01,
    SRC_DEAD  = 2'b10,
    SRC_POINT = 2'b11
  } pol_src_e;
endpackage

// File: rtl/dtc_sense_sync.sv
module dtc_sense_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dtc_point_gen.sv
module dtc_point_gen #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] cnt_pos,
  input  logic [CW-1:0] cnt_period,
  input  logic          center_mode,
  output logic          point
);
  logic [CW-1:0] half_pos;
  logic [CW-1:0] end_pos;

  always_comb begin
    half_pos = cnt_period >> 1;
    end_pos  = cnt_period - CW'(1);
    point    = center_mode ? (cnt_pos == half_pos) : (cnt_pos == end_pos);
  end
endmodule

// File: rtl/dtc_phase_latch.sv
module dtc_phase_latch
  import dtc_pol_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sense_s,
  input  logic     g_hi,
  input  logic     g_lo,
  input  logic     lim,
  input  logic     point,
  input  pol_src_e src,
  output logic     lat
);
  logic dead_now;
  logic dead_q;
  logic cand;
  logic close;

  assign dead_now = ~g_hi & ~g_lo;
  assign close    = dead_q & ~dead_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      dead_q <= 1'b0;
      cand   <= 1'b0;
      lat    <= 1'b0;
    end else begin
      dead_q <= dead_now;
      if (dead_now) cand <= sense_s;
      if (src == SRC_DEAD && close && !lim) lat <= cand;
      else if (src == SRC_POINT && point)   lat <= sense_s;
    end
  end

  AST_DEAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_DEAD && close && !lim) |=> lat == $past(cand)); // R3
  AST_BOUND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_DEAD && close && lim) |=> $stable(lat)); // R4
  AST_POINT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_POINT && !point) |=> $stable(lat)); // R10
  AST_POINT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_POINT && point) |=> lat == $past(sense_s)); // R7
  AST_SW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (src[1] == 1'b0) |=> $stable(lat)); // R10
endmodule

// File: rtl/dtc_polarity_top.sv
module dtc_polarity_top
  import dtc_pol_pkg::*;
#(
  parameter int NPH = 3,
  parameter int CW  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] sense_in,
  input  logic [NPH-1:0] gate_hi,
  input  logic [NPH-1:0] gate_lo,
  input  logic [CW-1:0]  cnt_pos,
  input  logic [CW-1:0]  cnt_period,
  input  logic           center_mode,
  input  logic [NPH-1:0] duty_limit,
  input  logic [NPH-1:0] sw_pol,
  input  logic [1:0]     corr_mode,
  output logic [NPH-1:0] pol_out
);
  pol_src_e       src;
  logic [NPH-1:0] sense_s;
  logic [NPH-1:0] lat;
  logic           point;

  assign src = pol_src_e'(corr_mode);

  dtc_sense_sync #(.W(NPH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(sense_in), .q(sense_s)
  );

  dtc_point_gen #(.CW(CW)) u_point (
    .cnt_pos(cnt_pos), .cnt_period(cnt_period),
    .center_mode(center_mode), .point(point)
  );

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_phase
      dtc_phase_latch u_lat (
        .clk(clk), .rst(rst), .sense_s(sense_s[p]),
        .g_hi(gate_hi[p]), .g_lo(gate_lo[p]), .lim(duty_limit[p]),
        .point(point), .src(src), .lat(lat[p])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                pol_out <= '0;
    else if (corr_mode[1])  pol_out <= lat;
    else                    pol_out <= sw_pol;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> pol_out == '0); // R1
  AST_SW_PASS: assert property (@(posedge clk) disable iff (rst)
    (corr_mode[1] == 1'b0) |=> pol_out == $past(sw_pol)); // R2
  AST_LAT_PASS: assert property (@(posedge clk) disable iff (rst)
    corr_mode[1] |=> pol_out == $past(lat)); // R8
endmodule

// File: tb/dtc_polarity_top_tb.sv
module dtc_polarity_top_tb;
  localparam int NPH = 3;
  localparam int CW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPH-1:0] sense_in = '0, gate_hi = '0, gate_lo = '0;
  logic [NPH-1:0] duty_limit = '0, sw_pol = '0;
  logic [CW-1:0]  cnt_pos = '0, cnt_period = 8'd10;
  logic           center_mode = 1'b1;
  logic [1:0]     corr_mode = 2'b00;
  logic [NPH-1:0] pol_out;

  int n_run = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  dtc_polarity_top #(.NPH(NPH), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .sense_in(sense_in), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .cnt_pos(cnt_pos), .cnt_period(cnt_period),
    .center_mode(center_mode), .duty_limit(duty_limit), .sw_pol(sw_pol),
    .corr_mode(corr_mode), .pol_out(pol_out)
  );

  // Reference model: behavioural, advanced at each rising edge
  int m_hist [$];
  bit m_dead_prev [NPH];
  bit m_last_dead [NPH];
  bit m_pol [NPH];
  bit m_out [NPH];

  always @(posedge clk) begin
    int synced;
    bit at_point;
    bit nxt_out [NPH];
    synced = (m_hist.size() >= 2) ? m_hist[1] : 0;
    at_point = center_mode ? (int'(cnt_pos) == int'(cnt_period) / 2)
                           : (int'(cnt_pos) == int'(cnt_period) - 1);
    for (int p = 0; p < NPH; p++) begin
      bit dead;
      nxt_out[p] = corr_mode[1] ? m_pol[p] : sw_pol[p];
      dead = !gate_hi[p] && !gate_lo[p];
      if (rst) begin
        m_pol[p] = 0; m_dead_prev[p] = 0; m_last_dead[p] = 0; nxt_out[p] = 0;
      end else begin
        if (corr_mode == 2'b10 && m_dead_prev[p] && !dead && !duty_limit[p])
          m_pol[p] = m_last_dead[p];
        else if (corr_mode == 2'b11 && at_point)
          m_pol[p] = synced[p];
        if (dead) m_last_dead[p] = synced[p];
        m_dead_prev[p] = dead;
      end
      m_out[p] = nxt_out[p];
    end
    if (rst) m_hist.delete();
    else begin
      m_hist.push_front(int'(sense_in));
      if (m_hist.size() > 2) void'(m_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    logic [NPH-1:0] exp_v;
    for (int p = 0; p < NPH; p++) exp_v[p] = m_out[p];
    if (!done) begin
      n_run++;
      if (pol_out !== exp_v) begin
        n_fail++;
        $display("FAIL %s: pol_out=%b expected=%b at %0t", cur_req, pol_out, exp_v, $time);
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one cycle of gate/counter activity; slot in 0..7 gives dead windows
  task automatic pwm_cycles(int n, bit rnd_sense);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int p = 0; p < NPH; p++) begin
        int s;
        s = (i + p) % 8;
        gate_hi[p] = (s < 3);
        gate_lo[p] = (s >= 5);
      end
      cnt_pos = (cnt_pos + 1 >= cnt_period) ? '0 : cnt_pos + 1;
      if (rnd_sense) sense_in = NPH'($urandom);
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    sense_in = 3'b111; sw_pol = 3'b101;
    step(5);
    @(negedge clk); rst = 0;

    cur_req = "R2";
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      sw_pol = NPH'(k * 5);
      corr_mode = (k % 2 == 0) ? 2'b00 : 2'b01;
    end

    cur_req = "R3";
    corr_mode = 2'b10;
    pwm_cycles(200, 1);

    cur_req = "R9";
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      sense_in = (k % 3 == 0) ? ~sense_in : sense_in;
      gate_hi = (k % 4 == 3) ? '1 : '0;
      gate_lo = '0;
    end

    cur_req = "R4";
    duty_limit = 3'b101;
    pwm_cycles(120, 1);
    duty_limit = 3'b111;
    pwm_cycles(60, 1);
    duty_limit = '0;

    cur_req = "R5";
    corr_mode = 2'b11; center_mode = 1; cnt_period = 8'd9;
    pwm_cycles(150, 1);

    cur_req = "R6";
    center_mode = 0; cnt_period = 8'd7;
    pwm_cycles(150, 1);

    cur_req = "R7";
    duty_limit = '1;
    gate_hi = '1; gate_lo = '0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      cnt_pos = (cnt_pos + 1 >= cnt_period) ? '0 : cnt_pos + 1;
      sense_in = NPH'($urandom);
    end
    duty_limit = '0;

    cur_req = "R10";
    cnt_period = 8'd200; cnt_pos = 8'd0; center_mode = 0;
    pwm_cycles(100, 1);
    corr_mode = 2'b01; cnt_period = 8'd5;
    pwm_cycles(80, 1);

    cur_req = "R8";
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      if (k % 7 == 0) corr_mode = 2'(k / 7);
      sw_pol = NPH'($urandom);
      sense_in = NPH'($urandom);
      cnt_pos = (cnt_pos + 1 >= cnt_period) ? '0 : cnt_pos + 1;
      gate_hi[0] = (k % 5 < 2); gate_lo[0] = (k % 5 == 4);
      gate_hi[1] = (k % 6 < 2); gate_lo[1] = (k % 6 > 3);
      gate_hi[2] = (k % 4 == 0); gate_lo[2] = (k % 4 == 2);
    end

    cur_req = "R1";
    @(negedge clk); rst = 1;
    step(3);
    @(negedge clk); rst = 0; corr_mode = 2'b11;
    step(2);

    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule